// File: doc/BRIEF.md
# Bunch Counter with Test-Pulse Trigger

This block keeps track of the bunch position inside an accelerator orbit. A 12-bit counter advances once per bunch clock and returns to zero on a bunch-crossing-zero strobe. When the strobe arrives, the block captures the count that was reached so it can be sent in the orbit message. It also checks that count against the expected orbit length and raises a sticky error flag when the two differ.

The same count drives a test-pulse trigger. Software selects a bunch number through an 8-bit match value that is compared with the low byte of the count. When triggering is enabled, a match produces a pulse one clock wide, and its active level can be programmed. The pulse, and a reset pulse derived from the strobe, are fanned out to two readout channels through a common register stage, so both channels see them on the same clock edge.

Top module: `bxt_bunch_timer`

## Requirements
- R1: `count` becomes 0 on the clock edge that samples `bc_zero` high and otherwise rises by one per clock, wrapping from 4095 to 0.
- R2: When `bc_zero` is sampled high and `count` is not 3563 (an orbit of 3564 bunches), `bunch_err` goes high on that edge. The first strobe after reset only aligns the counter and never raises the flag.
- R3: `orbit_count` takes the value `count` had on each edge that samples `bc_zero` high, and holds it at all other times.
- R4: Once raised, `bunch_err` stays high until an edge that samples `msg_sent` high. If a new mismatch occurs on that same edge, the flag stays high.
- R5: A test pulse is triggered when `pulse_en` is high and `count[7:0]` equals `match_val`. No pulse is triggered while `pulse_en` is low.
- R6: A test pulse lasts exactly one clock. A match in the clock right after a triggered match is ignored.
- R7: With `pulse_pol` = 1, `test_pulse` idles at 0 and is 1 while active. With `pulse_pol` = 0, it idles at 1 and is 0 while active. The active level appears two clock edges after the edge at which `count` took the matching value.
- R8: Both bits of `test_pulse` always carry the same value, and so do both bits of `chan_reset`. `chan_reset` is high for one clock, starting one edge after each edge that samples `bc_zero` high.
- R9: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bc_zero | input | 1 | Bunch-crossing-zero strobe |
| msg_sent | input | 1 | Orbit message has gone out; clears the error flag |
| pulse_en | input | 1 | Enables the test-pulse trigger |
| pulse_pol | input | 1 | Active level of the test pulse |
| match_val | input | 8 | Bunch number (low byte) at which the pulse fires |
| count | output | 12 | Current bunch count |
| orbit_count | output | 12 | Count captured at the last strobe |
| bunch_err | output | 1 | Sticky orbit-length mismatch flag |
| test_pulse | output | 2 | Per-channel test pulse |
| chan_reset | output | 2 | Per-channel reset pulse |

## Verification
The assertions assume that `rst_n` is released clear of a clock edge and that the control inputs change only between edges. They do not assume strobe spacing: orbits that are too short and strobes held for several clocks are legal. The stimulus changes every input at the falling edge. It includes correct orbits, a short orbit, a run long enough to wrap the counter, a strobe held for three clocks with the match set to bunch 0, and a message acknowledge that lands on the same edge as a mismatch.

// File: rtl/bxt_pkg.sv
package bxt_pkg;
  localparam int unsigned BXT_CNT_W     = 12;
  localparam int unsigned BXT_ORBIT_LEN = 3564;
  localparam int unsigned BXT_MATCH_W   = 8;
  localparam int unsigned BXT_NUM_CH    = 2;

  // Per-bunch control produced centrally and fanned out to channels
  typedef struct packed {
    logic pulse;
    logic rst;
  } bxt_ctl_t;
endpackage

// File: rtl/bxt_counter.sv
module bxt_counter #(
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned ORBIT_LEN = 3564
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bc_zero,
  input  logic             msg_sent,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] orbit_count,
  output logic             bunch_err,
  output logic             strobe_q
);
  localparam logic [CNT_W-1:0] LAST_BX = CNT_W'(ORBIT_LEN - 1);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] orb_q;
  logic             err_q, err_d;
  logic             armed_q, armed_d;
  logic             stb_q;
  logic             mismatch;

  always_comb begin
    cnt_d    = bc_zero ? '0 : cnt_q + ONE;
    armed_d  = armed_q | bc_zero;
    mismatch = bc_zero & armed_q & (cnt_q != LAST_BX);
    if (mismatch)      err_d = 1'b1;
    else if (msg_sent) err_d = 1'b0;
    else               err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      orb_q   <= '0;
      err_q   <= 1'b0;
      armed_q <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      if (bc_zero) orb_q <= cnt_q;
      err_q   <= err_d;
      armed_q <= armed_d;
      stb_q   <= bc_zero;
    end
  end

  assign count       = cnt_q;
  assign orbit_count = orb_q;
  assign bunch_err   = err_q;
  assign strobe_q    = stb_q;

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bc_zero |=> count == $past(count) + ONE);
  // R3
  orbit_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bc_zero |=> orbit_count == $past(count));
  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bunch_err && !msg_sent) |=> bunch_err);
endmodule

// File: rtl/bxt_pulse.sv
module bxt_pulse #(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned MATCH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   count,
  input  logic               pulse_en,
  input  logic [MATCH_W-1:0] match_val,
  output logic               fire
);
  logic fire_q, fire_d;
  logic hit;

  always_comb begin
    hit    = (count[MATCH_W-1:0] == match_val);
    fire_d = pulse_en & hit & ~fire_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fire_q <= 1'b0;
    else        fire_q <= fire_d;
  end

  assign fire = fire_q;

  // R6
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
  // R5
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(pulse_en));
endmodule

// File: rtl/bxt_fanout.sv
module bxt_fanout
  import bxt_pkg::*;
#(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bxt_ctl_t          ctl,
  input  logic              pulse_pol,
  output logic [NUM_CH-1:0] test_pulse,
  output logic [NUM_CH-1:0] chan_reset
);
  logic [NUM_CH-1:0] tp_q;
  logic [NUM_CH-1:0] rs_q;
  logic              tp_d;

  always_comb tp_d = pulse_pol ? ctl.pulse : ~ctl.pulse;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tp_q[ch] <= 1'b0;
        rs_q[ch] <= 1'b0;
      end else begin
        tp_q[ch] <= tp_d;
        rs_q[ch] <= ctl.rst;
      end
    end
  end

  assign test_pulse = tp_q;
  assign chan_reset = rs_q;

  // R8
  chan_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_pulse == {NUM_CH{test_pulse[0]}}) && (chan_reset == {NUM_CH{chan_reset[0]}}));
  // R7
  active_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.pulse |=> test_pulse[0] == $past(pulse_pol));
endmodule

// File: rtl/bxt_bunch_timer.sv
module bxt_bunch_timer
  import bxt_pkg::*;
#(
  parameter int unsigned CNT_W     = BXT_CNT_W,
  parameter int unsigned ORBIT_LEN = BXT_ORBIT_LEN,
  parameter int unsigned MATCH_W   = BXT_MATCH_W,
  parameter int unsigned NUM_CH    = BXT_NUM_CH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bc_zero,
  input  logic               msg_sent,
  input  logic               pulse_en,
  input  logic               pulse_pol,
  input  logic [MATCH_W-1:0] match_val,
  output logic [CNT_W-1:0]   count,
  output logic [CNT_W-1:0]   orbit_count,
  output logic               bunch_err,
  output logic [NUM_CH-1:0]  test_pulse,
  output logic [NUM_CH-1:0]  chan_reset
);
  logic     stb_q;
  logic     fire;
  bxt_ctl_t ctl;

  bxt_counter #(.CNT_W(CNT_W), .ORBIT_LEN(ORBIT_LEN)) u_counter (
    .clk(clk), .rst_n(rst_n), .bc_zero(bc_zero), .msg_sent(msg_sent),
    .count(count), .orbit_count(orbit_count), .bunch_err(bunch_err),
    .strobe_q(stb_q)
  );

  bxt_pulse #(.CNT_W(CNT_W), .MATCH_W(MATCH_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .count(count), .pulse_en(pulse_en),
    .match_val(match_val), .fire(fire)
  );

  always_comb begin
    ctl.pulse = fire;
    ctl.rst   = stb_q;
  end

  bxt_fanout #(.NUM_CH(NUM_CH)) u_fanout (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .pulse_pol(pulse_pol),
    .test_pulse(test_pulse), .chan_reset(chan_reset)
  );
endmodule

// File: tb/bxt_bunch_timer_bench.sv
`timescale 1ns/1ps
module bxt_bunch_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bc_zero, msg_sent, pulse_en, pulse_pol;
  logic [7:0]  match_val;
  logic [11:0] count, orbit_count;
  logic        bunch_err;
  logic [1:0]  test_pulse, chan_reset;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // reference model state
  int m_cnt, m_orb, m_err, m_armed, m_fire, m_tp, m_bcz, m_rst;

  always #2 clk = ~clk;

  bxt_bunch_timer u_bxt_bunch_timer (
    .clk(clk), .rst_n(rst_n), .bc_zero(bc_zero), .msg_sent(msg_sent),
    .pulse_en(pulse_en), .pulse_pol(pulse_pol), .match_val(match_val),
    .count(count), .orbit_count(orbit_count), .bunch_err(bunch_err),
    .test_pulse(test_pulse), .chan_reset(chan_reset)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_orb = 0; m_err = 0; m_armed = 0;
      m_fire = 0; m_tp = 0; m_bcz = 0; m_rst = 0;
    end else begin
      int n_fire;
      n_fire = (pulse_en && ((m_cnt % 256) == match_val) && !m_fire) ? 1 : 0;
      m_tp   = pulse_pol ? m_fire : (m_fire ? 0 : 1);
      m_fire = n_fire;
      m_rst  = m_bcz;
      m_bcz  = bc_zero;
      if (bc_zero && m_armed && m_cnt != 3563) m_err = 1;
      else if (msg_sent) m_err = 0;
      if (bc_zero) begin
        m_orb = m_cnt; m_armed = 1; m_cnt = 0;
      end else begin
        m_cnt = (m_cnt + 1) % 4096;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 count", count, m_cnt);
      chk("R3 orbit_count", orbit_count, m_orb);
      chk("R2/R4 bunch_err", bunch_err, m_err);
      chk("R5/R6/R7 test_pulse", test_pulse, m_tp ? 3 : 0);
      chk("R8 chan_reset", chan_reset, m_rst ? 3 : 0);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe();
    bc_zero = 1'b1;
    @(negedge clk);
    bc_zero = 1'b0;
  endtask

  task automatic do_orbit(int len);
    tick(len - 1);
    strobe();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bc_zero = 1'b0; msg_sent = 1'b0;
    pulse_en = 1'b0; pulse_pol = 1'b1; match_val = 8'd5;
    tick(3);
    // R9 reset state
    chk("R9 count", count, 0);
    chk("R9 orbit_count", orbit_count, 0);
    chk("R9 bunch_err", bunch_err, 0);
    chk("R9 test_pulse", test_pulse, 0);
    chk("R9 chan_reset", chan_reset, 0);
    rst_n = 1'b1;
    tick(100);
    strobe();
    // R2 first strobe only aligns
    chk("R2 first strobe", bunch_err, 0);
    tick(1);
    // R8 reset pulse one edge after strobe edge
    chk("R8 chan_reset", chan_reset, 3);
    pulse_en = 1'b1;
    tick(3562);
    strobe();
    chk("R2 good orbit", bunch_err, 0);
    chk("R3 good orbit", orbit_count, 3563);
    // R5/R7 pulse for bunch 5 shows two edges later
    tick(6);
    chk("R7 idle", test_pulse, 0);
    tick(1);
    chk("R5 pulse", test_pulse, 3);
    tick(1);
    chk("R6 one cycle", test_pulse, 0);
    tick(3563 - 8);
    strobe();
    chk("R2 second good orbit", bunch_err, 0);
    do_orbit(3000);
    chk("R2 short orbit", bunch_err, 1);
    chk("R3 short orbit", orbit_count, 2999);
    tick(10);
    chk("R4 sticky", bunch_err, 1);
    msg_sent = 1'b1; tick(1); msg_sent = 1'b0;
    chk("R4 cleared", bunch_err, 0);
    tick(1998 - 11);
    msg_sent = 1'b1;
    strobe();
    msg_sent = 1'b0;
    chk("R4 set wins", bunch_err, 1);
    msg_sent = 1'b1; tick(1); msg_sent = 1'b0;
    tick(3562);
    strobe();
    chk("R2 clean after clear", bunch_err, 0);
    // polarity low, match 200
    pulse_pol = 1'b0; match_val = 8'd200;
    tick(3);
    chk("R7 idle high", test_pulse, 3);
    tick(199);
    chk("R7 active low", test_pulse, 0);
    tick(1);
    chk("R7 back idle", test_pulse, 3);
    pulse_en = 1'b0;
    tick(300);
    chk("R5 disabled idle", test_pulse, 3);
    // R1 wrap
    strobe();
    tick(4200);
    chk("R1 wrap", count, 104);
    // held strobe with match at bunch 0
    pulse_en = 1'b1; pulse_pol = 1'b1; match_val = 8'd0;
    bc_zero = 1'b1;
    tick(3);
    bc_zero = 1'b0;
    chk("R2 held strobe", bunch_err, 1);
    tick(3);
    chk("R6 suppression", count, 3);
    tick(3564 * 2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule